// File: doc/BRIEF.md
# Split-Register Timestamp Counter Bank

The block keeps three free-running counters behind a read-only 32-bit register window. A wide timestamp counter (56 bits by default) advances on one strobe. A microsecond counter advances on a second strobe and an oscillator-cycle counter on a third. Prescalers outside the block derive all three strobes from one reference clock: nominally 31.25 MHz for the timestamp, 1 MHz for the microsecond count and 38.4 MHz for the oscillator count. A single-cycle read port returns the word at the requested byte offset one clock after the request.

The timestamp is wider than a bus word, so it is split into a low word and a zero-extended high word. The two halves are not latched together. A read of one half does not freeze the other, so a carry that lands between two software reads can produce a torn value.

The block also contains a hardware snapshot reader. After a start pulse it samples the high half, then the low half, then the high half again. It repeats the low and high samples until two consecutive high samples agree. It then publishes the joined value with a one-cycle done pulse and reports how many retries it needed.

Top module: `tsb_top`

## Requirements
- R1: While `tickTs` is high at a rising clock edge the timestamp counter increases by exactly one, wrapping to zero after 2^TS_W - 1.
- R2: A counter whose strobe is low at a clock edge keeps its value; the three counters advance independently of one another.
- R3: The microsecond counter increases by one on each edge with `tickUs` high and wraps modulo 2^CNT_W.
- R4: The oscillator counter increases by one on each edge with `tickOsc` high and wraps modulo 2^CNT_W.
- R5: With `rstN` low at a clock edge, all counters, `rdValid`, `rdData`, `snapDone`, `snapValue` and `snapRetries` become zero.
- R6: A read request (`rdEn` high at an edge) raises `rdValid` for the next cycle. `rdData` then holds the counter value present at the request edge. Offset 0x0 returns the low LO_W timestamp bits, and 0x4 returns the upper TS_W-LO_W bits with all higher bits zero. Offset 0x8 returns the microsecond count and 0xC the oscillator count, both zero-extended.
- R7: A read at any other byte offset, unaligned ones included, returns zero with `rdValid` high.
- R8: No shadow register joins the halves. A high-word read that follows a low-word read returns the high bits as they stand at its own request edge, including any carry taken since the low read.
- R9: After a `snapStart` pulse with no timestamp carry during the sequence, `snapDone` pulses once. At that pulse `snapValue` equals the timestamp and `snapRetries` is zero.
- R10: If the high half changes between the two high samples, the reader copies the newer high sample, samples the low half and the high half again, and increments `snapRetries` (saturating). The published value is `{high, low}` from the final agreeing pass.
- R11: `snapStart` is ignored while a snapshot is in progress, and `snapDone` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| tickTs | input | 1 | Timestamp advance strobe |
| tickUs | input | 1 | Microsecond advance strobe |
| tickOsc | input | 1 | Oscillator-count advance strobe |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Byte offset of the read |
| rdValid | output | 1 | Read data valid, one cycle after the request |
| rdData | output | DATA_W | Read data |
| snapStart | input | 1 | Begin a consistent timestamp snapshot |
| snapDone | output | 1 | One-cycle pulse when `snapValue` is updated |
| snapValue | output | TS_W | Consistent timestamp snapshot |
| snapRetries | output | RETRY_W | Retries used by the last snapshot |

## Verification
The assertions assume that each strobe is a plain level sampled at the clock edge, with no relation between the three strobes or to reads. They also assume that reset is held for at least one edge before the first checked cycle. The stimulus changes every input only on the falling edge, and raises reset from time zero for several cycles. It uses a reduced configuration (16-bit timestamp split 8/8, 8-bit side counters) so that wraps and low-word carries are reached in a few hundred cycles. Timestamp strobes are placed in exact cycles relative to the snapshot start, so a carry lands between the two high samples, before them, or not at all.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  localparam int unsigned OFF_TS_LO = 32'h0;
  localparam int unsigned OFF_TS_HI = 32'h4;
  localparam int unsigned OFF_US    = 32'h8;
  localparam int unsigned OFF_OSC   = 32'hC;

  typedef enum logic [2:0] {
    SN_IDLE,
    SN_HIA,
    SN_LO,
    SN_HIB,
    SN_CMP
  } snapState_t;

  typedef struct packed {
    logic capHiA;
    logic capLo;
    logic capHiB;
    logic rollHi;
    logic publish;
  } snapStrobes_t;

endpackage

// File: rtl/tsb_counter.sv
module tsb_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rstN)     count <= '0;
    else if (tick) count <= count + 1'b1;
  end

endmodule

// File: rtl/tsb_datapath.sv
module tsb_datapath
  import tsb_pkg::*;
#(
  parameter int TS_W   = 56,
  parameter int LO_W   = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickTs,
  input  logic                tickUs,
  input  logic                tickOsc,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  snapStrobes_t        strb,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [TS_W-1:0]     tsNow,
  output logic [CNT_W-1:0]    usNow,
  output logic [CNT_W-1:0]    oscNow,
  output logic                hiMatch,
  output logic [TS_W-1:0]     snapValue
);

  localparam int HI_W = TS_W - LO_W;

  logic [DATA_W-1:0] readWord;
  logic [HI_W-1:0]   hiA;
  logic [HI_W-1:0]   hiB;
  logic [LO_W-1:0]   loS;

  tsb_counter #(.W(TS_W)) tsCnt_i (
    .clk(clk), .rstN(rstN), .tick(tickTs), .count(tsNow)
  );

  tsb_counter #(.W(CNT_W)) usCnt_i (
    .clk(clk), .rstN(rstN), .tick(tickUs), .count(usNow)
  );

  tsb_counter #(.W(CNT_W)) oscCnt_i (
    .clk(clk), .rstN(rstN), .tick(tickOsc), .count(oscNow)
  );

  // Word select: only aligned, mapped offsets return data.
  always_comb begin
    readWord = '0;
    if (rdAddr == ADDR_W'(OFF_TS_LO))      readWord = DATA_W'(tsNow[LO_W-1:0]);
    else if (rdAddr == ADDR_W'(OFF_TS_HI)) readWord = DATA_W'(tsNow[TS_W-1:LO_W]);
    else if (rdAddr == ADDR_W'(OFF_US))    readWord = DATA_W'(usNow);
    else if (rdAddr == ADDR_W'(OFF_OSC))   readWord = DATA_W'(oscNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      rdData  <= rdEn ? readWord : '0;
    end
  end

  // Snapshot sample registers, steered by the control strobes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiA       <= '0;
      hiB       <= '0;
      loS       <= '0;
      snapValue <= '0;
    end else begin
      if (strb.capHiA)  hiA <= tsNow[TS_W-1:LO_W];
      if (strb.rollHi)  hiA <= hiB;
      if (strb.capLo)   loS <= tsNow[LO_W-1:0];
      if (strb.capHiB)  hiB <= tsNow[TS_W-1:LO_W];
      if (strb.publish) snapValue <= {hiB, loS};
    end
  end

  assign hiMatch = (hiA == hiB);

endmodule

// File: rtl/tsb_snap_ctrl.sv
module tsb_snap_ctrl
  import tsb_pkg::*;
#(
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               snapStart,
  input  logic               hiMatch,
  output snapStrobes_t       strb,
  output logic               snapDone,
  output logic [RETRY_W-1:0] snapRetries
);

  snapState_t state;
  snapState_t stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      SN_IDLE: if (snapStart) stateNext = SN_HIA;
      SN_HIA: begin
        strb.capHiA = 1'b1;
        stateNext   = SN_LO;
      end
      SN_LO: begin
        strb.capLo = 1'b1;
        stateNext  = SN_HIB;
      end
      SN_HIB: begin
        strb.capHiB = 1'b1;
        stateNext   = SN_CMP;
      end
      SN_CMP: begin
        if (hiMatch) begin
          strb.publish = 1'b1;
          stateNext    = SN_IDLE;
        end else begin
          strb.rollHi = 1'b1;
          stateNext   = SN_LO;
        end
      end
      default: stateNext = SN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= SN_IDLE;
      snapDone    <= 1'b0;
      snapRetries <= '0;
    end else begin
      state    <= stateNext;
      snapDone <= strb.publish;
      if (state == SN_IDLE && snapStart)           snapRetries <= '0;
      else if (strb.rollHi && snapRetries != '1)   snapRetries <= snapRetries + 1'b1;
    end
  end

endmodule

// File: rtl/tsb_top.sv
module tsb_top
  import tsb_pkg::*;
#(
  parameter int TS_W    = 56,
  parameter int LO_W    = 32,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickTs,
  input  logic               tickUs,
  input  logic               tickOsc,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  input  logic               snapStart,
  output logic               snapDone,
  output logic [TS_W-1:0]    snapValue,
  output logic [RETRY_W-1:0] snapRetries
);

  snapStrobes_t      strb;
  logic              hiMatch;
  logic [TS_W-1:0]   tsNow;
  logic [CNT_W-1:0]  usNow;
  logic [CNT_W-1:0]  oscNow;

  tsb_datapath #(
    .TS_W(TS_W), .LO_W(LO_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .tickTs(tickTs), .tickUs(tickUs), .tickOsc(tickOsc),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb),
    .rdValid(rdValid), .rdData(rdData),
    .tsNow(tsNow), .usNow(usNow), .oscNow(oscNow),
    .hiMatch(hiMatch), .snapValue(snapValue)
  );

  tsb_snap_ctrl #(.RETRY_W(RETRY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .snapStart(snapStart), .hiMatch(hiMatch),
    .strb(strb), .snapDone(snapDone), .snapRetries(snapRetries)
  );

endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int TS_W   = 56,
  parameter int LO_W   = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickTs,
  input logic              tickUs,
  input logic              tickOsc,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              snapDone,
  input logic [TS_W-1:0]   tsNow,
  input logic [CNT_W-1:0]  usNow,
  input logic [CNT_W-1:0]  oscNow
);

  localparam int HI_W = TS_W - LO_W;

  logic mappedAddr;
  assign mappedAddr = (rdAddr == ADDR_W'(0)) || (rdAddr == ADDR_W'(4)) ||
                      (rdAddr == ADDR_W'(8)) || (rdAddr == ADDR_W'(12));

  p_ts_inc_r1: assert property (@(posedge clk) disable iff (!rstN)
    tickTs |=> tsNow == TS_W'($past(tsNow) + 1'b1));

  p_ts_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickTs |=> $stable(tsNow));

  p_us_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickUs |=> $stable(usNow));

  p_osc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickOsc |=> $stable(oscNow));

  p_us_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    tickUs |=> usNow == CNT_W'($past(usNow) + 1'b1));

  p_osc_inc_r4: assert property (@(posedge clk) disable iff (!rstN)
    tickOsc |=> oscNow == CNT_W'($past(oscNow) + 1'b1));

  p_reset_clear_r5: assert property (@(posedge clk)
    !rstN |=> (tsNow == '0 && usNow == '0 && oscNow == '0 && !rdValid && !snapDone));

  p_rd_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  p_rd_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  p_hi_zext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_W'(4)) |=> (rdData >> HI_W) == '0);

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mappedAddr) |=> rdData == '0);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    snapDone |=> !snapDone);

endmodule

bind tsb_top tsb_checker #(
  .TS_W(TS_W), .LO_W(LO_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .tickTs(tickTs), .tickUs(tickUs), .tickOsc(tickOsc),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
  .snapDone(snapDone), .tsNow(tsNow), .usNow(usNow), .oscNow(oscNow)
);

// File: tb/tsb_top_tb_top.sv
module tsb_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TS_W    = 16;
  localparam int LO_W    = 8;
  localparam int CNT_W   = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int RETRY_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickTs = 1'b0, tickUs = 1'b0, tickOsc = 1'b0;
  logic rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic rdValid;
  logic [DATA_W-1:0] rdData;
  logic snapStart = 1'b0;
  logic snapDone;
  logic [TS_W-1:0] snapValue;
  logic [RETRY_W-1:0] snapRetries;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  longint tsModel = 0, usModel = 0, oscModel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsb_top #(
    .TS_W(TS_W), .LO_W(LO_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .RETRY_W(RETRY_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .tickTs(tickTs), .tickUs(tickUs), .tickOsc(tickOsc),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .snapStart(snapStart), .snapDone(snapDone), .snapValue(snapValue),
    .snapRetries(snapRetries)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint expRead(input int addr);
    case (addr)
      0:  return tsModel & 64'hFF;
      4:  return (tsModel >> 8) & 64'hFF;
      8:  return usModel & 64'hFF;
      12: return oscModel & 64'hFF;
      default: return 0;
    endcase
  endfunction

  task automatic readReg(input int addr, input string req);
    longint exp;
    @(negedge clk);
    rdEn = 1'b1;
    rdAddr = ADDR_W'(addr);
    exp = expRead(addr);
    @(negedge clk);
    rdEn = 1'b0;
    check(rdValid == 1'b1, {req, " valid"}, longint'(rdValid), 1);
    check(longint'(rdData) == exp, req, longint'(rdData), exp);
  endtask

  task automatic tickMany(input int n, input bit sTs, input bit sUs, input bit sOsc);
    if (n > 0) begin
      @(negedge clk);
      tickTs = sTs; tickUs = sUs; tickOsc = sOsc;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tickTs = 1'b0; tickUs = 1'b0; tickOsc = 1'b0;
      if (sTs)  tsModel  = (tsModel + n) % 65536;
      if (sUs)  usModel  = (usModel + n) % 256;
      if (sOsc) oscModel = (oscModel + n) % 256;
    end
  endtask

  task automatic bringLowTo(input int target);
    tickMany(int'((target - (tsModel & 255) + 256) % 256), 1'b1, 1'b0, 1'b0);
  endtask

  // mode 0: quiet, 1: carry between high samples, 2: extra start while busy,
  // 3: tick before the first high sample
  task automatic snapRun(input int mode, input longint expVal, input int expRetries, input string req);
    int dones = 0;
    longint got;
    @(negedge clk);
    snapStart = 1'b1;
    if (mode == 3) tickTs = 1'b1;
    @(posedge clk);
    @(negedge clk);
    snapStart = 1'b0;
    tickTs = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (mode == 1) tickTs = 1'b1;
    if (mode == 2) snapStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tickTs = 1'b0;
    snapStart = 1'b0;
    if (mode == 1 || mode == 3) tsModel = (tsModel + 1) % 65536;
    for (int i = 0; i < 20; i++) begin
      if (snapDone) dones++;
      @(negedge clk);
    end
    got = longint'(snapValue);
    check(dones == 1, {req, " done pulses"}, dones, 1);
    check(got == expVal, {req, " value"}, got, expVal);
    check(int'(snapRetries) == expRetries, {req, " retries"}, longint'(snapRetries), expRetries);
  endtask

  task automatic sweepReads(input string req);
    for (int a = 0; a <= 64; a++) readReg(a, req);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    // R5: reset state, including a read request held during reset
    rdEn = 1'b1;
    tickTs = 1'b1; tickUs = 1'b1; tickOsc = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rdValid == 1'b0, "R5 rdValid", longint'(rdValid), 0);
    check(rdData == '0, "R5 rdData", longint'(rdData), 0);
    check(snapDone == 1'b0, "R5 snapDone", longint'(snapDone), 0);
    check(snapRetries == '0, "R5 snapRetries", longint'(snapRetries), 0);
    check(snapValue == '0, "R5 snapValue", longint'(snapValue), 0);
    rdEn = 1'b0;
    tickTs = 1'b0; tickUs = 1'b0; tickOsc = 1'b0;
    rstN = 1'b1;
    sweepReads("R5 R6 R7 zero after reset");

    // R1 R2 R3 R4: independent advance
    tickMany(37, 1'b1, 1'b0, 1'b0);
    tickMany(11, 1'b0, 1'b1, 1'b0);
    tickMany(5, 1'b0, 1'b0, 1'b1);
    sweepReads("R2 R6 R7 independent counters");
    tickMany(300, 1'b1, 1'b1, 1'b1);
    sweepReads("R1 R3 R4 R6 after carry and side wraps");

    // R3 R4: side counters wrap exactly at their width
    tickMany(int'(256 - usModel), 1'b0, 1'b1, 1'b0);
    readReg(8, "R3 us wrap to zero");
    tickMany(int'(256 - oscModel), 1'b0, 1'b0, 1'b1);
    readReg(12, "R4 osc wrap to zero");

    // R8: torn read across a low-word carry
    bringLowTo(255);
    readReg(0, "R8 low before carry");
    tickMany(1, 1'b1, 1'b0, 1'b0);
    readReg(4, "R8 high after carry");
    readReg(0, "R8 low after carry");

    // R9: quiet snapshot
    snapRun(0, tsModel, 0, "R9 quiet snapshot");

    // R10: carry between the two high samples forces one retry
    bringLowTo(255);
    snapRun(1, (tsModel + 1) % 65536, 1, "R10 retry on carry");

    // R9: carry before the first high sample needs no retry
    bringLowTo(255);
    snapRun(3, (tsModel + 1) % 65536, 0, "R9 carry before sampling");

    // R11: second start during a snapshot is ignored
    snapRun(2, tsModel, 0, "R11 start while busy");

    // R1: full timestamp wrap
    tickMany(65536, 1'b1, 1'b0, 1'b0);
    readReg(0, "R1 low after full wrap");
    readReg(4, "R1 high after full wrap");
    bringLowTo(255);
    tickMany(int'(65536 - tsModel), 1'b1, 1'b0, 1'b0);
    readReg(0, "R1 low at wrap to zero");
    readReg(4, "R1 high at wrap to zero");
    snapRun(0, 0, 0, "R9 snapshot at zero");

    finished = 1'b1;
    finishRun();
  end

endmodule